// File: doc/BRIEF.md
# Three-of-Six Delay-Insensitive Link Codec

This block connects two independently clocked nodes over a six-wire parallel link that needs no shared clock and no matched wire delays. Each symbol is sent as a constant-weight word with exactly three of the six wires high. The receiver can therefore tell that a word has fully arrived by counting the wires that are high. Between symbols all wires return to zero, and a single acknowledge wire runs back from the receiver to complete a four-phase return-to-zero handshake.

The transmit half accepts either a 4-bit data nibble or one of four control symbols. It drives the matching codeword and holds it until the acknowledge rises. It then drives the all-zero spacer and reports ready again once the acknowledge has fallen. The receive half registers the incoming wires through two flops and classifies the word:
- fewer than three wires high means the word is still arriving;
- exactly three means a complete word, which is decoded into a data nibble or a control indication;
- more than three means an error, which is latched.

The whole handshake is modelled synchronously to the local clock for simulation.

Top module: `tri6_link_codec`

## Requirements
- R1: The 20 six-bit values with exactly three bits set, sorted in ascending numeric order, form the codebook. Index 0 is 6'b000111 and index 19 is 6'b111000. A data nibble n is sent as codebook entry n, and a received entry n below 16 decodes to rx_data = n with rx_is_ctrl = 0.
- R2: With tx_ctrl = 1, tx_sym[1:0] selects a control symbol: 0 start-of-packet (entry 16, 6'b110001), 1 end-of-packet (entry 17, 6'b110010), 2 idle (entry 18, 6'b110100), 3 reserved (entry 19, 6'b111000). A received entry 16+k decodes to rx_is_ctrl = 1 and rx_data = k.
- R3: tx_wires is only ever all zero or a weight-3 codeword. A driven codeword stays unchanged until it returns to all zero.
- R4: The transmitter holds its codeword while tx_ack_in is low. It drives the spacer only after tx_ack_in has been seen high, and it raises tx_ready only after tx_ack_in has been seen low again. While tx_ready is high, tx_wires is zero.
- R5: A received word with fewer than three wires high raises neither rx_ack, rx_valid nor rx_err.
- R6: A received word with exactly three wires high raises rx_ack and gives a single-cycle rx_valid pulse. The decoded rx_data and rx_is_ctrl are presented with the pulse and held until the next accepted word.
- R7: rx_ack falls only after the registered input is all zero. A different codeword arriving while rx_ack is high is ignored.
- R8: A received word with more than three wires high sets rx_err and does not raise rx_ack.
- R9: rx_err stays set until err_clr is asserted or reset is applied.
- R10: After reset, tx_ready = 1, and tx_wires, rx_ack, rx_valid and rx_err are all zero.
- R11: rx_wires passes through two register stages. A complete word that is stable on rx_wires before rising edge 1 produces rx_ack and rx_valid after rising edge 3 and not after rising edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| tx_valid | input | 1 | Request to send one symbol (taken while tx_ready) |
| tx_ctrl | input | 1 | 1 = control symbol, 0 = data nibble |
| tx_sym | input | 4 | Data nibble, or control selector in bits [1:0] |
| tx_ready | output | 1 | Transmitter idle and able to take a symbol |
| tx_wires | output | 6 | Outgoing three-of-six code |
| tx_ack_in | input | 1 | Acknowledge returned by the far receiver |
| rx_wires | input | 6 | Incoming three-of-six code |
| rx_ack | output | 1 | Acknowledge returned to the far transmitter |
| rx_valid | output | 1 | One-cycle pulse for each accepted word |
| rx_is_ctrl | output | 1 | Last accepted word was a control symbol |
| rx_data | output | 4 | Last accepted nibble or control selector |
| err_clr | input | 1 | Clears the latched error flag |
| rx_err | output | 1 | Latched flag for a word with more than three wires high |

## Verification
The checker checks several rules on every cycle:
- the weight of the outgoing code and that a driven codeword stays stable;
- that tx_ready is only high with the wires at zero;
- that rx_valid coincides with a rising acknowledge;
- that the acknowledge falls only after a zero registered input;
- that the error flag is sticky.

The codebook mapping in both directions can only be shown by the bench's scenarios. So can the split between incomplete, valid and over-weight words across all 64 input patterns, the three-edge receive latency, and the way the transmitter stalls on a withheld acknowledge. These scenarios run a loopback sweep of every symbol and drive the receive wires directly.

// File: rtl/tri6_link_codec.sv
module tri6_link_codec #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_valid,
  input  logic         tx_ctrl,
  input  logic [3:0]   tx_sym,
  output logic         tx_ready,
  output logic [W-1:0] tx_wires,
  input  logic         tx_ack_in,
  input  logic [W-1:0] rx_wires,
  output logic         rx_ack,
  output logic         rx_valid,
  output logic         rx_is_ctrl,
  output logic [3:0]   rx_data,
  input  logic         err_clr,
  output logic         rx_err
);
  localparam int NV = 1 << W;

  function automatic logic [W-1:0] encode(input logic [4:0] idx);
    int n;
    encode = '0;
    n = 0;
    for (int v = 0; v < NV; v++) begin
      if ($countones(v[W-1:0]) == 3) begin
        if (n == int'(idx)) encode = v[W-1:0];
        n++;
      end
    end
  endfunction

  function automatic logic [4:0] rank(input logic [W-1:0] code);
    int n;
    n = 0;
    for (int v = 0; v < NV; v++)
      if (v < int'(code) && $countones(v[W-1:0]) == 3) n++;
    rank = 5'(n);
  endfunction

  typedef enum logic [1:0] {T_IDLE, T_DRIVE, T_SPACE} tx_st_t;
  tx_st_t st;
  logic a1, a2;
  logic [4:0] tx_idx;

  assign tx_idx   = tx_ctrl ? {3'b100, tx_sym[1:0]} : {1'b0, tx_sym};
  assign tx_ready = (st == T_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= T_IDLE;
      tx_wires <= '0;
      a1 <= 1'b0;
      a2 <= 1'b0;
    end else begin
      a1 <= tx_ack_in;
      a2 <= a1;
      case (st)
        T_IDLE:  if (tx_valid) begin
                   tx_wires <= encode(tx_idx);
                   st <= T_DRIVE;
                 end
        T_DRIVE: if (a2) begin
                   tx_wires <= '0;
                   st <= T_SPACE;
                 end
        default: if (!a2) st <= T_IDLE;
      endcase
    end
  end

  logic [W-1:0] q1, q2;
  logic [3:0]   wt;
  logic [4:0]   rx_idx;

  assign wt     = 4'($countones(q2));
  assign rx_idx = rank(q2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= '0;
      q2 <= '0;
      rx_ack <= 1'b0;
      rx_valid <= 1'b0;
      rx_is_ctrl <= 1'b0;
      rx_data <= '0;
      rx_err <= 1'b0;
    end else begin
      q1 <= rx_wires;
      q2 <= q1;
      rx_valid <= 1'b0;
      if (!rx_ack && wt == 4'd3) begin
        rx_ack <= 1'b1;
        rx_valid <= 1'b1;
        rx_is_ctrl <= rx_idx[4];
        rx_data <= rx_idx[4] ? {2'b00, rx_idx[1:0]} : rx_idx[3:0];
      end else if (rx_ack && q2 == '0) begin
        rx_ack <= 1'b0;
      end
      if (wt > 4'd3) rx_err <= 1'b1;
      else if (err_clr) rx_err <= 1'b0;
    end
  end
endmodule

module tri6_link_codec_chk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_ready,
  input logic [W-1:0] tx_wires,
  input logic [W-1:0] q2,
  input logic         rx_ack,
  input logic         rx_valid,
  input logic         rx_err,
  input logic         err_clr
);
  // R3
  tx_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tx_wires) == 0 || $countones(tx_wires) == 3));
  // R3
  tx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wires != '0) |=> (tx_wires == $past(tx_wires) || tx_wires == '0));
  // R4
  tx_ready_spacer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (tx_wires == '0));
  // R6
  rx_valid_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $rose(rx_ack));
  // R7
  rx_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ack) |-> ($past(q2) == '0));
  // R9
  rx_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !err_clr) |=> rx_err);
endmodule

bind tri6_link_codec tri6_link_codec_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .tx_wires(tx_wires),
  .q2(q2), .rx_ack(rx_ack), .rx_valid(rx_valid), .rx_err(rx_err),
  .err_clr(err_clr)
);

// File: tb/sim_tri6_link_codec.sv
module sim_tri6_link_codec;
  logic clk = 0, rst_n = 0;
  logic tx_valid = 0, tx_ctrl = 0, err_clr = 0;
  logic [3:0] tx_sym = 0;
  logic tx_ready, rx_ack, rx_valid, rx_is_ctrl, rx_err;
  logic [5:0] tx_wires, rx_wires, drv_rx = 0;
  logic [3:0] rx_data;
  logic loop = 0, drv_ack = 0;
  int checks = 0, errors = 0, vcnt = 0;

  always #2.5 clk = ~clk;

  assign rx_wires = loop ? tx_wires : drv_rx;

  tri6_link_codec u0 (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ctrl(tx_ctrl),
    .tx_sym(tx_sym), .tx_ready(tx_ready), .tx_wires(tx_wires),
    .tx_ack_in(loop ? rx_ack : drv_ack), .rx_wires(rx_wires),
    .rx_ack(rx_ack), .rx_valid(rx_valid), .rx_is_ctrl(rx_is_ctrl),
    .rx_data(rx_data), .err_clr(err_clr), .rx_err(rx_err));

  always @(posedge clk) if (rx_valid) vcnt <= vcnt + 1;

  function automatic int wt(input int v);
    int c = 0;
    for (int b = 0; b < 6; b++) c += (v >> b) & 1;
    return c;
  endfunction

  function automatic int code_of(input int idx);
    int n = 0;
    for (int v = 0; v < 64; v++)
      if (wt(v) == 3) begin
        if (n == idx) return v;
        n++;
      end
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input bit c, input int s);
    int v0;
    wait (tx_ready);
    @(negedge clk);
    tx_ctrl = c; tx_sym = 4'(s); tx_valid = 1;
    v0 = vcnt;
    @(negedge clk);
    tx_valid = 0;
    chk(tx_wires == 6'(code_of(c ? 16 + s : s)), c ? "R2 tx code" : "R1 tx code",
        tx_wires, code_of(c ? 16 + s : s));
    wait (vcnt != v0);
    @(negedge clk);
    chk(rx_is_ctrl == c && rx_data == 4'(s), c ? "R2 rx decode" : "R1 rx decode",
        {rx_is_ctrl, rx_data}, {c, 4'(s)});
    wait (tx_ready);
    @(negedge clk);
  endtask

  int watchdog_hit = 0;
  initial begin
    repeat (150000) @(posedge clk);
    watchdog_hit = 1;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(tx_ready && tx_wires == 0 && !rx_ack && !rx_valid && !rx_err,
        "R10 reset", {tx_ready, tx_wires, rx_ack, rx_valid, rx_err}, 9'b100000000);

    // R4 stall while ack withheld
    tx_sym = 4'd5; tx_ctrl = 0; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    cyc(10);
    chk(!tx_ready && tx_wires == 6'(code_of(5)), "R4 hold code", tx_wires, code_of(5));
    drv_ack = 1;
    cyc(5);
    chk(tx_wires == 0 && !tx_ready, "R4 spacer wait", {tx_ready, tx_wires}, 0);
    cyc(10);
    chk(!tx_ready, "R4 ready held", tx_ready, 0);
    drv_ack = 0;
    cyc(5);
    chk(tx_ready && tx_wires == 0, "R4 ready back", tx_ready, 1);

    // R1 R2 loopback sweep
    loop = 1;
    for (int n = 0; n < 16; n++) send(0, n);
    for (int k = 0; k < 4; k++) send(1, k);
    loop = 0;
    cyc(5);

    // R11 latency
    @(negedge clk);
    drv_rx = 6'(code_of(3));
    @(negedge clk); @(negedge clk);
    chk(!rx_ack && !rx_valid, "R11 not after edge 2", rx_ack, 0);
    @(negedge clk);
    chk(rx_ack && rx_valid, "R11 after edge 3", {rx_ack, rx_valid}, 3);
    // R7 ignore new word while ack high
    drv_rx = 6'(code_of(9));
    cyc(6);
    chk(rx_ack && rx_data == 4'd3, "R7 ignored while acked", rx_data, 3);
    drv_rx = 0;
    cyc(5);
    chk(!rx_ack, "R7 drop on spacer", rx_ack, 0);

    // R5 gradual arrival
    drv_rx = 6'b000001; cyc(5);
    drv_rx = 6'b000011; cyc(5);
    chk(!rx_ack && !rx_err, "R5 partial wait", rx_ack, 0);
    drv_rx = 6'b000111; cyc(5);
    chk(rx_ack && rx_data == 0 && !rx_is_ctrl, "R6 completed", rx_data, 0);
    drv_rx = 0; cyc(5);

    // exhaustive 64 patterns
    for (int p = 0; p < 64; p++) begin
      int v0, w, idx;
      w = wt(p);
      idx = 0;
      for (int q = 0; q < p; q++) if (wt(q) == 3) idx++;
      v0 = vcnt;
      drv_rx = 6'(p);
      cyc(6);
      if (w < 3)
        chk(!rx_ack && vcnt == v0 && !rx_err, "R5 incomplete", {rx_ack, rx_err}, 0);
      else if (w == 3)
        chk(rx_ack && vcnt == v0 + 1 &&
            rx_is_ctrl == (idx >= 16) &&
            rx_data == (idx >= 16 ? 4'(idx - 16) : 4'(idx)),
            "R6 accept", {rx_is_ctrl, rx_data}, idx);
      else
        chk(rx_err && !rx_ack, "R8 overweight", {rx_err, rx_ack}, 2);
      drv_rx = 0;
      cyc(6);
      if (w > 3) begin
        chk(rx_err, "R9 err latched", rx_err, 1);
        err_clr = 1; @(negedge clk); err_clr = 0; @(negedge clk);
        chk(!rx_err, "R9 err cleared", rx_err, 0);
      end
    end

    // R9 reset clears
    drv_rx = 6'b111111; cyc(5);
    drv_rx = 0; cyc(5);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk(!rx_err, "R9 reset clears", rx_err, 0);

    if (!watchdog_hit) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule